// File: doc/BRIEF.md
# Recency-Ordered Port Arbiter

This block picks one winner among up to N requesting ports. It is meant to serve as a single grant or accept arbiter inside an iterative crossbar scheduler. Priority comes from a recency list of port indices rather than from a rotating pointer. The port at the head of the list was served longest ago and has the highest priority. The port at the tail was served most recently and has the lowest.

Each cycle the arbiter scans the request vector against the list and grants the requester that sits closest to the head. The result is a one-hot grant and its binary index, both taken combinationally from the current request and the stored list. When the surrounding scheduler reports that the grant was used, by raising the update strobe, the granted index moves to the tail. Every entry that stood behind it moves one place toward the head. Entries ahead of it keep their positions. The whole list is presented on an output bus so that its order can be seen.

Top module: `lru_order_arbiter`

## Requirements
- R1: While reset is high, and after it is released, the list holds index k in slot k (slot 0 is the head), that is 0,1,...,N-1. Slot k of `order_o` occupies bits [k*W +: W], where W = clog2(N).
- R2: When at least one request bit is set, exactly one grant bit is set. It belongs to the requesting port whose index appears in the lowest-numbered slot of the list.
- R3: When no request bit is set, `gnt_o` is all zeros and `gnt_vld_o` is low.
- R4: On a clock edge with `upd_i` high and a grant present, the granted index is written to slot N-1. Slots behind the granted index's old slot each take the value of the slot one place further back. Slots ahead of it are unchanged.
- R5: On a clock edge with `upd_i` high and no request bit set, the list is unchanged.
- R6: On a clock edge with `upd_i` low, the list is unchanged, whatever the requests.
- R7: The list is at all times a permutation of 0..N-1.
- R8: When `gnt_vld_o` is high, `gnt_idx_o` is the position of the single set bit of `gnt_o`. When it is low, `gnt_idx_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | N | Request vector, bit p set when port p requests |
| upd_i | input | 1 | Grant was used; move the granted index to the tail |
| gnt_o | output | N | One-hot grant |
| gnt_idx_o | output | W | Binary index of the granted port |
| gnt_vld_o | output | 1 | A grant is present |
| order_o | output | N*W | Recency list, slot 0 (least recent) in the low bits |

## Verification
The assertions assume only that reset is held for at least one edge before any check counts. They also assume that `req_i` and `upd_i` settle before each rising edge. No ordering between the update strobe and the request vector is assumed, because an update with no request must be harmless. The bench changes inputs only at falling edges, and it deliberately includes updates with an empty request vector. It also includes updates of the head slot, the tail slot and interior slots, so that every shift shape is reached.

// File: rtl/lru_arb_pkg.sv
package lru_arb_pkg;
  // Width of an index able to name any of n ports (at least one bit).
  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lru_slot_match.sv
// Marks each list slot whose stored port index is currently requesting.
module lru_slot_match #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0]   req,
  input  logic [N*W-1:0] order,
  output logic [N-1:0]   hit
);
  for (genvar k = 0; k < N; k++) begin : g_slot
    logic [W-1:0] port;
    assign port   = order[k*W +: W];
    assign hit[k] = (int'(port) < N) ? req[port] : 1'b0;
  end
endmodule

// File: rtl/lru_head_pick.sv
// Finds the lowest-numbered slot with a live request.
module lru_head_pick #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] hit,
  output logic [W-1:0] pos,
  output logic         any
);
  always_comb begin
    pos = '0;
    any = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hit[k]) begin
        pos = W'(k);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lru_order_list.sv
// Holds the recency list; on an update removes one slot and appends its index.
module lru_order_list #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           move_en,
  input  logic [W-1:0]   move_pos,
  input  logic [W-1:0]   move_idx,
  output logic [N*W-1:0] order
);
  logic [W-1:0] slot_q [N];
  logic [W-1:0] slot_d [N];

  always_comb begin
    for (int k = 0; k < N; k++) begin
      if (!move_en || k < int'(move_pos)) slot_d[k] = slot_q[k];
      else if (k == N - 1)                slot_d[k] = move_idx;
      else                                slot_d[k] = slot_q[k + 1];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (rst) slot_q[k] <= W'(k);
      else     slot_q[k] <= slot_d[k];
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_flat
    assign order[k*W +: W] = slot_q[k];
  end
endmodule

// File: rtl/lru_order_arbiter.sv
module lru_order_arbiter #(
  parameter int N = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_i,
  input  logic [N-1:0]                        req_i,
  input  logic                                upd_i,
  output logic [N-1:0]                        gnt_o,
  output logic [lru_arb_pkg::idx_width(N)-1:0] gnt_idx_o,
  output logic                                gnt_vld_o,
  output logic [N*lru_arb_pkg::idx_width(N)-1:0] order_o
);
  localparam int W = lru_arb_pkg::idx_width(N);

  logic [N-1:0] hit;
  logic [W-1:0] win_pos;
  logic         win_any;
  logic [W-1:0] win_idx;

  lru_slot_match #(.N(N), .W(W)) u_match (
    .req   (req_i),
    .order (order_o),
    .hit   (hit)
  );

  lru_head_pick #(.N(N), .W(W)) u_pick (
    .hit (hit),
    .pos (win_pos),
    .any (win_any)
  );

  assign win_idx = win_any ? order_o[win_pos*W +: W] : '0;

  lru_order_list #(.N(N), .W(W)) u_list (
    .clk      (clk_i),
    .rst      (rst_i),
    .move_en  (upd_i & win_any),
    .move_pos (win_pos),
    .move_idx (win_idx),
    .order    (order_o)
  );

  assign gnt_vld_o = win_any;
  assign gnt_idx_o = win_idx;
  always_comb begin
    gnt_o = '0;
    if (win_any) gnt_o[win_idx] = 1'b1;
  end
endmodule

// File: rtl/lru_order_arbiter_chk.sv
module lru_order_arbiter_chk #(
  parameter int N = 8,
  parameter int W = 3
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   req,
  input logic           upd,
  input logic [N-1:0]   gnt,
  input logic [W-1:0]   idx,
  input logic           vld,
  input logic [N*W-1:0] order
);
  logic [(1<<W)-1:0] seen;
  always_comb begin
    seen = '0;
    for (int k = 0; k < N; k++) seen[order[k*W +: W]] = 1'b1;
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~req) == '0));
  p_some_r2: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> vld);
  p_none_r3: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> (gnt == '0 && !vld));
  p_idx_r8: assert property (@(posedge clk) disable iff (rst)
    vld |-> (gnt[idx] && $countones(gnt) == 1));
  p_tail_r4: assert property (@(posedge clk) disable iff (rst)
    (upd && vld) |=> (order[(N-1)*W +: W] == $past(idx)));
  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (upd && req == '0) |=> $stable(order));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(order));
  p_perm_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(seen[N-1:0]) == N);
endmodule

bind lru_order_arbiter lru_order_arbiter_chk #(.N(N), .W(W)) u_chk (
  .clk   (clk_i),
  .rst   (rst_i),
  .req   (req_i),
  .upd   (upd_i),
  .gnt   (gnt_o),
  .idx   (gnt_idx_o),
  .vld   (gnt_vld_o),
  .order (order_o)
);

// File: tb/lru_order_arbiter_test.sv
module lru_order_arbiter_test;
  localparam int N = 8;
  localparam int W = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   req = '0;
  logic           upd = 1'b0;
  logic [N-1:0]   gnt;
  logic [W-1:0]   gidx;
  logic           gvld;
  logic [N*W-1:0] order;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  int model [N];
  string last_op = "R1";

  always #5 clk = ~clk;

  lru_order_arbiter #(.N(N)) uut (
    .clk_i(clk), .rst_i(rst), .req_i(req), .upd_i(upd),
    .gnt_o(gnt), .gnt_idx_o(gidx), .gnt_vld_o(gvld), .order_o(order)
  );

  task automatic check(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Compare list against model and confirm the model is a permutation.
  task automatic check_list(string tag);
    int seen;
    seen = 0;
    for (int k = 0; k < N; k++) begin
      check(tag, longint'(order[k*W +: W]), longint'(model[k]));
      seen = seen | (1 << model[k]);
    end
    check("R7", longint'(seen), longint'((1 << N) - 1));
  endtask

  // One cycle: drive at falling edge, check, advance model for the rising edge.
  task automatic step(logic [N-1:0] r, logic u);
    int pos;
    int win;
    @(negedge clk);
    check_list(last_op);
    req = r;
    upd = u;
    #1;
    pos = -1;
    for (int k = 0; k < N; k++) if (pos < 0 && r[model[k]]) pos = k;
    win = (pos >= 0) ? model[pos] : -1;
    if (pos < 0) begin
      check("R3", longint'(gnt), 0);
      check("R3", longint'(gvld), 0);
      check("R8", longint'(gidx), 0);
    end else begin
      check("R2", longint'(gnt), longint'(1) << win);
      check("R2", longint'(gvld), 1);
      check("R8", longint'(gidx), longint'(win));
    end
    if (!u) last_op = "R6";
    else if (pos < 0) last_op = "R5";
    else begin
      last_op = "R4";
      for (int k = pos; k < N - 1; k++) model[k] = model[k + 1];
      model[N - 1] = win;
    end
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < N; k++) model[k] = k;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_list("R1");
    rst = 1'b0;
    // Full request: head served each time, list rotates.
    for (int i = 0; i < 10; i++) step('1, 1'b1);
    // Requests held but never used: list must not move.
    for (int i = 0; i < 4; i++) step(8'hA5, 1'b0);
    // Update with empty request vector.
    step('0, 1'b1);
    step('0, 1'b0);
    // Single requester at tail, then head, then interior.
    step(8'(1) << model[N - 1], 1'b1);
    step(8'(1) << model[0], 1'b1);
    step(8'(1) << model[3], 1'b1);
    // Sparse patterns.
    step(8'h81, 1'b1);
    step(8'h18, 1'b1);
    step(8'h42, 1'b0);
    // Random mix.
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] r;
      r = 8'($urandom);
      if ($urandom_range(0, 3) == 0) r = '0;
      step(r, 1'($urandom_range(0, 1)));
    end
    step('0, 1'b0);
    // Reset restores ascending order.
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    for (int k = 0; k < N; k++) model[k] = k;
    check_list("R1");
    finish_run();
  end
endmodule